// File: doc/BRIEF.md
# Radio Link Frame Serializer

This block turns one radio link protocol frame into a serial bit stream of fixed length. Each frame starts with a handshake on a request port. That port carries the header word together with three selects: frame size (short or long), protocol version code, and frame class (unnumbered, or supervisory / information-plus-supervisory). The block then sends the header bits. Next it pulls the information bits one at a time from a ready/valid bit port. Last it appends a 24-bit check field, which an embedded CRC-24 unit computes over the header and information bits.

Frames are aligned to the radio slots, so the stream has no flags, delimiters or stuffed bits. A frame that has started always runs to its last check bit. If the information source falls behind, the block does not insert fill bits. It holds its output valid low and raises an underrun indication until the next bit arrives. The controller is a state machine with five states:
- `ST_IDLE` waits for a request.
- `ST_HEADER` shifts out the header.
- `ST_INFO` forwards the information bits.
- `ST_FCS` shifts out the check field.
- `ST_DONE` is a single gap cycle.

The transitions are:
- IDLE→HEADER on an accepted request.
- HEADER→INFO after the last header bit.
- INFO→FCS after the last information bit.
- FCS→DONE on the last check bit.
- DONE→IDLE unconditionally.

Top module: `rlf_frame_serializer`

## Requirements
- R1: A frame has exactly 240 output bits when `frm_long` is 0 and exactly 576 output bits when `frm_long` is 1. The count includes header, information and check field.
- R2: The header is 24 bits wide only when `frm_ver` equals 2 and `frm_sup` is 1. For every other version code, and for unnumbered frames (`frm_sup`=0), it is 16 bits wide. The header is taken from the low bits of `frm_hdr` and sent most significant bit first.
- R3: The information field length is the frame length minus the header length minus 24. Its bits are forwarded in the order they are accepted on the `info_*` port.
- R4: The last 24 bits are the check field, sent highest-order bit first. They are the ones complement of the CRC remainder. The remainder uses generator x^24+x^23+x^21+x^20+x^19+x^17+x^16+x^15+x^13+x^8+x^7+x^5+x^4+x^2+1, a register preset to all ones, and header plus information bits shifted in first bit first. Running that same division over all bits of a frame therefore leaves 0x6D8930.
- R5: The header word and the selects are captured on the cycle `frm_valid` and `frm_ready` are both high. Changing them later in the frame has no effect on that frame.
- R6: After reset, and between frames, `frm_ready` is 1 and `out_valid`, `info_ready`, `frame_done` and `underrun` are 0. `frm_ready` is 1 only in the idle state.
- R7: While an information bit is needed (`info_ready`=1) and `info_valid` is 0, `out_valid` is 0 and `underrun` is 1. No fill bit is emitted.
- R8: Once the first bit of a frame has been output, every cycle up to the last check bit outputs a bit, except cycles with `underrun`=1. The frame cannot be aborted.
- R9: `frame_done` is a one-cycle pulse on the cycle the last check bit is output. In the following cycle both `frm_ready` and `out_valid` are 0, and in the cycle after that `frm_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Frame request |
| frm_ready | output | 1 | Serializer idle, request accepted when both high |
| frm_hdr | input | 24 | Header word, low 16 or 24 bits used |
| frm_long | input | 1 | Frame size: 0 = 240 bits, 1 = 576 bits |
| frm_ver | input | 2 | Protocol version code |
| frm_sup | input | 1 | Frame class: 1 = supervisory or info-plus-supervisory |
| info_valid | input | 1 | Information bit present |
| info_ready | output | 1 | Information bit needed this cycle |
| info_bit | input | 1 | Information bit |
| out_valid | output | 1 | A frame bit is on `out_bit` this cycle |
| out_bit | output | 1 | Serial frame bit |
| frame_done | output | 1 | Last check bit of the frame is on `out_bit` |
| underrun | output | 1 | Information bit needed but not available |

## Verification
Each frame-size, version and class combination is driven, including version 2 unnumbered frames and version code 3. This catches a header decoder that keys on the version alone or on the class alone, which would shift every later bit and put the check field in the wrong place. Information stalls are injected both at random and densely. A design that padded instead of stalling would lengthen the frame and corrupt the information field, and one that lost the counter during a stall would emit the wrong count. After every frame the check residue and the gap cycle after `frame_done` are checked. The selects are scrambled straight after acceptance to expose any design that reads them live.

// File: rtl/rlf_pkg.sv
package rlf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_INFO,
        ST_FCS,
        ST_DONE
    } ser_state_t;

    typedef struct packed {
        logic long_frm;
        logic wide_hdr;
    } frame_cfg_t;

endpackage

// File: rtl/rlf_crc_unit.sv
module rlf_crc_unit #(
    parameter int          W    = 24,
    parameter logic [W-1:0] POLY = 24'hBBA1B5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] rem
);

    logic         fb;
    logic [W-1:0] rem_next;

    always_comb begin
        fb       = rem[W-1] ^ din;
        rem_next = {rem[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '1;
        end else if (clear) begin
            rem <= '1;
        end else if (shift_en) begin
            rem <= rem_next;
        end
    end

endmodule

// File: rtl/rlf_field_len.sv
module rlf_field_len
    import rlf_pkg::*;
#(
    parameter int SHORT_LEN  = 240,
    parameter int LONG_LEN   = 576,
    parameter int NARROW_HDR = 16,
    parameter int WIDE_HDR   = 24,
    parameter int CHK_W      = 24,
    parameter int CNT_W      = 10
) (
    input  frame_cfg_t       cfg,
    output logic [CNT_W-1:0] hdr_len,
    output logic [CNT_W-1:0] info_len
);

    logic [CNT_W-1:0] total_len;

    always_comb begin
        total_len = cfg.long_frm ? CNT_W'(LONG_LEN) : CNT_W'(SHORT_LEN);
        hdr_len   = cfg.wide_hdr ? CNT_W'(WIDE_HDR) : CNT_W'(NARROW_HDR);
        info_len  = total_len - hdr_len - CNT_W'(CHK_W);
    end

endmodule

// File: rtl/rlf_bit_counter.sv
module rlf_bit_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             last
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec) begin
            count <= count - CNT_W'(1);
        end
    end

    assign last = (count == CNT_W'(1));

endmodule

// File: rtl/rlf_frame_serializer.sv
module rlf_frame_serializer
    import rlf_pkg::*;
#(
    parameter int SHORT_LEN  = 240,
    parameter int LONG_LEN   = 576,
    parameter int NARROW_HDR = 16,
    parameter int HDR_W      = 24,
    parameter int CHK_W      = 24,
    parameter int VER_W      = 2,
    parameter int WIDE_VER   = 2,
    parameter logic [CHK_W-1:0] CRC_POLY = 24'hBBA1B5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_valid,
    output logic             frm_ready,
    input  logic [HDR_W-1:0] frm_hdr,
    input  logic             frm_long,
    input  logic [VER_W-1:0] frm_ver,
    input  logic             frm_sup,
    input  logic             info_valid,
    output logic             info_ready,
    input  logic             info_bit,
    output logic             out_valid,
    output logic             out_bit,
    output logic             frame_done,
    output logic             underrun
);

    localparam int CNT_W  = $clog2(LONG_LEN + 1);
    localparam int HIDX_W = $clog2(HDR_W);
    localparam int CIDX_W = $clog2(CHK_W);

    ser_state_t       state_q, state_d;
    logic [HDR_W-1:0] hdr_q;
    frame_cfg_t       cfg_q, cfg_in, cfg_sel;
    logic [CNT_W-1:0] hdr_len, info_len;
    logic [CNT_W-1:0] cnt;
    logic             cnt_last;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_load_val;
    logic             cnt_dec;
    logic [CHK_W-1:0] crc_rem;
    logic             crc_clear, crc_en, crc_din;
    logic             accept;
    logic [HIDX_W-1:0] hdr_idx;
    logic [CIDX_W-1:0] chk_idx;

    // Frame configuration: wide header only for version WIDE_VER S / I+S frames
    always_comb begin
        cfg_in.long_frm = frm_long;
        cfg_in.wide_hdr = (frm_ver == VER_W'(WIDE_VER)) && frm_sup;
        cfg_sel         = (state_q == ST_IDLE) ? cfg_in : cfg_q;
    end

    rlf_field_len #(
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN),
        .NARROW_HDR(NARROW_HDR),
        .WIDE_HDR  (HDR_W),
        .CHK_W     (CHK_W),
        .CNT_W     (CNT_W)
    ) u_len (
        .cfg     (cfg_sel),
        .hdr_len (hdr_len),
        .info_len(info_len)
    );

    rlf_bit_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_load_val),
        .dec     (cnt_dec),
        .count   (cnt),
        .last    (cnt_last)
    );

    rlf_crc_unit #(
        .W   (CHK_W),
        .POLY(CRC_POLY)
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (crc_clear),
        .shift_en(crc_en),
        .din     (crc_din),
        .rem     (crc_rem)
    );

    // State register and frame capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hdr_q   <= '0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                hdr_q <= frm_hdr;
                cfg_q <= cfg_in;
            end
        end
    end

    // Next state and bit counter control
    always_comb begin
        state_d      = state_q;
        cnt_load     = 1'b0;
        cnt_load_val = '0;
        cnt_dec      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (frm_valid) begin
                    state_d      = ST_HEADER;
                    cnt_load     = 1'b1;
                    cnt_load_val = hdr_len;
                end
            end
            ST_HEADER: begin
                if (cnt_last) begin
                    state_d      = ST_INFO;
                    cnt_load     = 1'b1;
                    cnt_load_val = info_len;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_INFO: begin
                if (info_valid) begin
                    if (cnt_last) begin
                        state_d      = ST_FCS;
                        cnt_load     = 1'b1;
                        cnt_load_val = CNT_W'(CHK_W);
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
            end
            ST_FCS: begin
                if (cnt_last) begin
                    state_d = ST_DONE;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign hdr_idx = HIDX_W'(cnt - CNT_W'(1));
    assign chk_idx = CIDX_W'(cnt - CNT_W'(1));

    // Outputs
    always_comb begin
        frm_ready  = 1'b0;
        info_ready = 1'b0;
        out_valid  = 1'b0;
        out_bit    = 1'b0;
        frame_done = 1'b0;
        underrun   = 1'b0;
        accept     = 1'b0;
        crc_clear  = 1'b0;
        crc_en     = 1'b0;
        crc_din    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                frm_ready = 1'b1;
                accept    = frm_valid;
                crc_clear = frm_valid;
            end
            ST_HEADER: begin
                out_valid = 1'b1;
                out_bit   = hdr_q[hdr_idx];
                crc_en    = 1'b1;
                crc_din   = hdr_q[hdr_idx];
            end
            ST_INFO: begin
                info_ready = 1'b1;
                out_valid  = info_valid;
                out_bit    = info_valid & info_bit;
                underrun   = !info_valid;
                crc_en     = info_valid;
                crc_din    = info_bit;
            end
            ST_FCS: begin
                out_valid  = 1'b1;
                out_bit    = ~crc_rem[chk_idx];
                frame_done = cnt_last;
            end
            ST_DONE: begin
                frm_ready = 1'b0;
            end
            default: begin
                frm_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rlf_serializer_checker.sv
module rlf_serializer_checker #(
    parameter int SHORT_LEN = 240,
    parameter int LONG_LEN  = 576
) (
    input logic clk,
    input logic rst_n,
    input logic frm_valid,
    input logic frm_ready,
    input logic frm_long,
    input logic info_ready,
    input logic out_valid,
    input logic frame_done,
    input logic underrun
);

    localparam int CW = $clog2(LONG_LEN + 1);

    logic [CW-1:0] bits_seen;
    logic [CW-1:0] exp_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_seen <= '0;
            exp_len   <= '0;
        end else if (frm_valid && frm_ready) begin
            bits_seen <= '0;
            exp_len   <= frm_long ? CW'(LONG_LEN) : CW'(SHORT_LEN);
        end else if (out_valid) begin
            bits_seen <= bits_seen + CW'(1);
        end
    end

    p_frame_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (32'(bits_seen) + 1 == 32'(exp_len)));

    p_ready_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ready |-> (!out_valid && !info_ready && !underrun));

    p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (!out_valid && info_ready));

    p_no_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !frame_done) |=> (out_valid || underrun));

    p_done_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (!out_valid && !frm_ready && !frame_done));

    p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> ##1 frm_ready);

endmodule

bind rlf_frame_serializer rlf_serializer_checker #(
    .SHORT_LEN(SHORT_LEN),
    .LONG_LEN (LONG_LEN)
) u_chk (.*);

// File: tb/rlf_frame_serializer_test.sv
module rlf_frame_serializer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0;
    logic        frm_ready;
    logic [23:0] frm_hdr = '0;
    logic        frm_long = 1'b0;
    logic [1:0]  frm_ver = '0;
    logic        frm_sup = 1'b0;
    logic        info_valid = 1'b0;
    logic        info_ready;
    logic        info_bit = 1'b0;
    logic        out_valid;
    logic        out_bit;
    logic        frame_done;
    logic        underrun;

    int n_chk  = 0;
    int n_fail = 0;

    logic exp_bits [576];
    logic got_bits [576];
    logic info_src [536];

    always #5 clk = ~clk;

    rlf_frame_serializer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid),
        .frm_ready (frm_ready),
        .frm_hdr   (frm_hdr),
        .frm_long  (frm_long),
        .frm_ver   (frm_ver),
        .frm_sup   (frm_sup),
        .info_valid(info_valid),
        .info_ready(info_ready),
        .info_bit  (info_bit),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .frame_done(frame_done),
        .underrun  (underrun)
    );

    function automatic logic [23:0] crc_step(input logic [23:0] r, input logic b);
        logic [23:0] n;
        n = {r[22:0], 1'b0};
        if (r[23] ^ b) n = n ^ 24'hBBA1B5;
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input bit lng, input logic [1:0] ver, input bit sup,
                             input logic [23:0] hdr, input int stall_pct);
        int total, hl, il, idx, got, ip, cyc, done_at, gap_bad, und_bad;
        int bad_h, bad_i, bad_c;
        bit done;
        logic [23:0] rem;
        total = lng ? 576 : 240;
        hl    = (ver == 2'd2 && sup) ? 24 : 16;
        il    = total - hl - 24;
        idx   = 0;
        rem   = '1;
        for (int i = hl - 1; i >= 0; i--) begin
            exp_bits[idx] = hdr[i];
            rem = crc_step(rem, hdr[i]);
            idx++;
        end
        for (int i = 0; i < il; i++) begin
            info_src[i] = 1'($urandom % 2);
            exp_bits[idx] = info_src[i];
            rem = crc_step(rem, info_src[i]);
            idx++;
        end
        for (int i = 23; i >= 0; i--) begin
            exp_bits[idx] = ~rem[i];
            idx++;
        end

        @(negedge clk);
        frm_valid = 1'b1;
        frm_long  = lng;
        frm_ver   = ver;
        frm_sup   = sup;
        frm_hdr   = hdr;
        info_valid = 1'b0;
        #1;
        check(frm_ready == 1'b1, "R6", "frm_ready at request", int'(frm_ready), 1);

        @(negedge clk);
        frm_valid = 1'b0;
        frm_long  = 1'($urandom % 2);
        frm_ver   = 2'($urandom % 4);
        frm_sup   = 1'($urandom % 2);
        frm_hdr   = 24'($urandom);   // R5: later changes must not matter

        got = 0; ip = 0; cyc = 0; done = 0; done_at = -1; gap_bad = 0; und_bad = 0;
        while (!done && cyc < 4000) begin
            info_valid = (($urandom % 100) >= stall_pct);
            info_bit   = (ip < il) ? info_src[ip] : 1'b0;
            #1;
            if (out_valid) begin
                if (got < 576) got_bits[got] = out_bit;
                got++;
            end else if (!underrun) begin
                gap_bad++;
            end
            if (underrun != (info_ready && !info_valid)) und_bad++;
            if (info_valid && info_ready) ip++;
            if (frame_done) begin
                done = 1;
                done_at = got;
            end
            cyc++;
            @(negedge clk);
        end
        info_valid = 1'b0;
        #1;
        check(!frm_ready && !out_valid, "R9", "gap cycle after frame_done",
              int'(frm_ready) + int'(out_valid), 0);
        @(negedge clk);
        #1;
        check(frm_ready == 1'b1, "R9", "ready two cycles after frame_done", int'(frm_ready), 1);

        check(done, "R9", "frame_done seen", int'(done), 1);
        check(got == total, "R1", "frame length", got, total);
        check(done_at == total, "R9", "frame_done on last bit", done_at, total);

        bad_h = 0; bad_i = 0; bad_c = 0;
        rem = '1;
        for (int i = 0; i < total && i < got; i++) begin
            rem = crc_step(rem, got_bits[i]);
            if (got_bits[i] !== exp_bits[i]) begin
                if (i < hl) bad_h++;
                else if (i < hl + il) bad_i++;
                else bad_c++;
            end
        end
        check(bad_h == 0, "R2", "header bit mismatches", bad_h, 0);
        check(bad_i == 0, "R3", "info bit mismatches", bad_i, 0);
        check(bad_c == 0, "R4", "check bit mismatches", bad_c, 0);
        check(rem == 24'h6D8930, "R4", "receiver residue", int'(rem), int'(24'h6D8930));
        check(gap_bad == 0, "R8", "idle cycles inside frame", gap_bad, 0);
        check(und_bad == 0, "R7", "underrun vs stall mismatches", und_bad, 0);
        check(ip == il, "R3", "info bits consumed", ip, il);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(frm_ready == 1'b1, "R6", "reset frm_ready", int'(frm_ready), 1);
        check(!out_valid && !frame_done && !underrun && !info_ready, "R6",
              "reset outputs quiet",
              int'(out_valid) + int'(frame_done) + int'(underrun) + int'(info_ready), 0);

        // directed corners
        run_frame(1'b0, 2'd0, 1'b0, 24'hA5C3F0, 0);   // short, narrow header
        run_frame(1'b0, 2'd2, 1'b1, 24'h81FF3C, 0);   // short, wide header
        run_frame(1'b1, 2'd2, 1'b1, 24'hFFFFFF, 20);  // long, wide header
        run_frame(1'b1, 2'd1, 1'b1, 24'h123456, 0);   // version 1 supervisory: narrow
        run_frame(1'b0, 2'd2, 1'b0, 24'h00FFFF, 10);  // version 2 unnumbered: narrow
        run_frame(1'b1, 2'd3, 1'b1, 24'h000000, 0);   // other version code: narrow
        run_frame(1'b0, 2'd2, 1'b1, 24'h5A5A5A, 70);  // dense stalls

        for (int k = 0; k < 12; k++) begin
            run_frame(1'($urandom % 2), 2'($urandom % 4), 1'($urandom % 2),
                      24'($urandom), int'($urandom % 40));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule